// File: doc/BRIEF.md
# Reset-Aware Memory Request Sequencer

This block sits between the request generator of a processor core and the pins of its two memory ports: one for instruction fetch, one for data. In normal running it hands the generator's request, sequential and burst-continuation signals straight to the ports. When the active-low core reset is applied, it forces both ports to show an internal (idle) cycle. The point at which that forcing takes hold depends on the clock level at the moment reset falls. If the clock is high, the forcing is immediate. If the clock is low, it waits for the next rising edge.

The reset input is sampled on falling clock edges. The block treats a falling edge that sees reset high, with no dip since the previous falling edge, as the release point. After that point it keeps both ports idle for a fixed number of cycles before the first real access is let through. A short reset pulse is latched by the block even when it begins and ends inside a single low phase of the clock, and such a pulse triggers the full release wait.

Top module: `mem_req_reset_seq`

## Requirements
- R1: While the reset input is low, the outputs sampled in any high phase of the clock show the idle encoding.
- R2: The idle encoding is instruction request high, instruction sequential low, data request high, data sequential low, burst continuation low. Packed as {ireq_n, iseq, dreq_n, dseq, dmore}, it is 5'b10100.
- R3: When reset falls while the clock is high, all five outputs show the idle encoding in that same high phase, without waiting for any clock edge.
- R4: When reset falls while the clock is low, the outputs keep passing the generator values for the rest of that low phase. They show the idle encoding from the next rising edge.
- R5: The release of reset is recognized only at a falling clock edge. A rising edge that comes between the release and that falling edge does not start the wait.
- R6: Let the first rising edge after the recognizing falling edge be edge E. The outputs stay idle in the cycles that begin at E and at E+1. The first generator request is passed at rising edge E+2 (RELEASE_WAIT = 2).
- R7: While reset is low and during the release wait, the generator inputs have no effect on the outputs.
- R8: Once the wait has ended, each output equals its generator input combinationally, cycle after cycle.
- R9: A reset pulse that falls and rises within one low phase of the clock makes the outputs idle from the next rising edge. The full wait then runs from the next falling edge.
- R10: A reset pulse that falls and rises within one high phase of the clock also restarts the full wait, counted from the falling edge that ends that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low core reset, sampled on falling clock edges |
| gen_ireq_n | input | 1 | Generator instruction request, active low |
| gen_iseq | input | 1 | Generator instruction sequential flag |
| gen_dreq_n | input | 1 | Generator data request, active low |
| gen_dseq | input | 1 | Generator data sequential flag |
| gen_dmore | input | 1 | Generator data burst-continuation flag |
| ireq_n | output | 1 | Instruction port request, active low |
| iseq | output | 1 | Instruction port sequential flag |
| dreq_n | output | 1 | Data port request, active low |
| dseq | output | 1 | Data port sequential flag |
| dmore | output | 1 | Data port burst-continuation flag |

## Verification
Results arrive at different times, and each check is timed to match. A reset that falls in the high phase is due at once, so it is checked a fraction of a nanosecond later. A reset that falls in the low phase is due only at the next rising edge, so the bench checks twice before that edge that the old value is still present, and once just after it that the ports are idle. After a release, the count runs from the first rising edge that follows the recognizing falling edge. The bench checks a quarter period after each of the two idle edges, and after the edge at which the first request must appear. Pass-through is combinational, so the bench checks it half a nanosecond after each change to the generator inputs.

// File: rtl/mrs_pkg.sv
`timescale 1ns/1ps
// Package: shared request bundle for the reset-aware request sequencer.
// Assumes the field order below is the packed order used at all checks.
package mrs_pkg;

    typedef struct packed {
        logic ireq_n;
        logic iseq;
        logic dreq_n;
        logic dseq;
        logic dmore;
    } mem_req_t;

    localparam mem_req_t REQ_IDLE = '{ireq_n: 1'b1, iseq: 1'b0,
                                      dreq_n: 1'b1, dseq: 1'b0,
                                      dmore: 1'b0};

endpackage

// File: rtl/mrs_fall_sampler.sv
`timescale 1ns/1ps
// mrs_fall_sampler: turns the reset level into "reset released" as seen
// at falling clock edges. A drop of rst_n clears the flag at once. The flag
// sets again only at a falling edge that finds rst_n high.
// Assumes rst_n is free of glitches shorter than a flop recovery time.
module mrs_fall_sampler (
    input  logic clk,
    input  logic rst_n,
    output logic rel_seen_q
);

    // Falling-edge sample of reset, cleared whenever reset dips.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_seen_q <= 1'b0;
        end else begin
            rel_seen_q <= 1'b1;
        end
    end

endmodule

// File: rtl/mrs_dip_catcher.sv
`timescale 1ns/1ps
// mrs_dip_catcher: records that reset was low at some point since the
// last rising edge. It catches pulses that open and close between two
// rising edges, whichever clock phase they fall in.
// Assumes rst_n is active low and may change at any time.
module mrs_dip_catcher (
    input  logic clk,
    input  logic rst_n,
    output logic dip_q
);

    // Set on any reset drop, cleared at a rising edge that sees reset high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dip_q <= 1'b1;
        end else begin
            dip_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mrs_release_timer.sv
`timescale 1ns/1ps
// mrs_release_timer: holds the ports idle through reset and then through
// RELEASE_WAIT rising edges after the release has been seen at a falling edge.
// Its synchronous active-low reset is rel_seen (the sampled release).
// Assumes RELEASE_WAIT >= 1.
module mrs_release_timer #(
    parameter int RELEASE_WAIT = 2
) (
    input  logic clk,
    input  logic rel_seen,
    input  logic dip,
    output logic hold_q
);

    localparam int CNT_W = (RELEASE_WAIT < 2) ? 1 : $clog2(RELEASE_WAIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_WAIT);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] wait_cnt_q;

    // Count rising edges since the sampled release and drop hold at the end.
    always_ff @(posedge clk) begin
        if (!rel_seen) begin
            hold_q     <= 1'b1;
            wait_cnt_q <= '0;
        end else if (dip) begin
            // Dip already released before this edge: this edge is the first one.
            hold_q     <= 1'b1;
            wait_cnt_q <= CNT_ONE;
        end else if (hold_q) begin
            if (wait_cnt_q == CNT_LAST) begin
                hold_q <= 1'b0;
            end else begin
                wait_cnt_q <= wait_cnt_q + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/mrs_idle_mux.sv
`timescale 1ns/1ps
// mrs_idle_mux: selects the idle encoding or the generator bundle. The
// forcing comes from the hold state, or from a reset dip seen during
// the high phase of the clock.
// Assumes clk is a clean clock, since it takes part in the select.
module mrs_idle_mux
    import mrs_pkg::*;
(
    input  logic     clk,
    input  logic     dip,
    input  logic     hold,
    input  mem_req_t gen_req,
    output mem_req_t port_req
);

    logic force_idle;

    // Forcing is immediate in the high phase and deferred in the low phase.
    always_comb begin
        force_idle = hold | (clk & dip);
        port_req   = force_idle ? REQ_IDLE : gen_req;
    end

endmodule

// File: rtl/mem_req_reset_seq.sv
`timescale 1ns/1ps
// mem_req_reset_seq: reset handling for the instruction and data memory
// ports. It forces internal cycles during reset and for RELEASE_WAIT cycles
// after a release that has been sampled at a falling edge, and passes the
// generator requests through at all other times.
// Assumes the generator drives its bundle from a single clock domain.
module mem_req_reset_seq
    import mrs_pkg::*;
#(
    parameter int RELEASE_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_ireq_n,
    input  logic gen_iseq,
    input  logic gen_dreq_n,
    input  logic gen_dseq,
    input  logic gen_dmore,
    output logic ireq_n,
    output logic iseq,
    output logic dreq_n,
    output logic dseq,
    output logic dmore
);

    logic     rel_seen;
    logic     dip;
    logic     hold;
    mem_req_t gen_req;
    mem_req_t port_req;

    // Gather the generator pins into one bundle.
    always_comb begin
        gen_req = '{ireq_n: gen_ireq_n, iseq: gen_iseq, dreq_n: gen_dreq_n,
                    dseq: gen_dseq, dmore: gen_dmore};
    end

    mrs_fall_sampler i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .rel_seen_q (rel_seen)
    );

    mrs_dip_catcher i_dip (
        .clk   (clk),
        .rst_n (rst_n),
        .dip_q (dip)
    );

    mrs_release_timer #(
        .RELEASE_WAIT (RELEASE_WAIT)
    ) i_timer (
        .clk      (clk),
        .rel_seen (rel_seen),
        .dip      (dip),
        .hold_q   (hold)
    );

    mrs_idle_mux i_mux (
        .clk      (clk),
        .dip      (dip),
        .hold     (hold),
        .gen_req  (gen_req),
        .port_req (port_req)
    );

    // Spread the port bundle back onto the pins.
    always_comb begin
        ireq_n = port_req.ireq_n;
        iseq   = port_req.iseq;
        dreq_n = port_req.dreq_n;
        dseq   = port_req.dseq;
        dmore  = port_req.dmore;
    end

endmodule

// File: rtl/mrs_chk.sv
`timescale 1ns/1ps
// mrs_chk: timing properties of the sequencer, seen only at its pins.
// It counts falling edges since the last reset dip on its own.
module mrs_chk #(
    parameter int RELEASE_WAIT = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] gen_v,
    input logic [4:0] out_v
);

    localparam int CW = $clog2(RELEASE_WAIT + 2);
    localparam logic [CW-1:0] WAIT_V = CW'(RELEASE_WAIT);
    localparam logic [CW-1:0] DONE_V = CW'(RELEASE_WAIT + 1);
    localparam logic [4:0]    IDLE_V = 5'b10100;

    logic [CW-1:0] rel_cnt;

    // Falling edges with reset high since the last dip, saturating.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_cnt <= '0;
        end else if (rel_cnt != DONE_V) begin
            rel_cnt <= rel_cnt + 1'b1;
        end
    end

    // R1
    rst_idle_chk: assert property (@(negedge clk) !rst_n |-> out_v == IDLE_V);

    // R6
    wait_idle_chk: assert property (@(negedge clk) disable iff (!rst_n)
        rel_cnt <= WAIT_V |-> out_v == IDLE_V);

    // R8
    pass_thru_chk: assert property (@(negedge clk) disable iff (!rst_n)
        rel_cnt == DONE_V |-> out_v == gen_v);

    // R6
    first_access_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (rel_cnt == DONE_V && $past(rel_cnt) == WAIT_V) |-> out_v == gen_v);

endmodule

bind mem_req_reset_seq mrs_chk #(.RELEASE_WAIT(RELEASE_WAIT)) u_mrs_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .gen_v ({gen_ireq_n, gen_iseq, gen_dreq_n, gen_dseq, gen_dmore}),
    .out_v ({ireq_n, iseq, dreq_n, dseq, dmore})
);

// File: tb/test_mem_req_reset_seq.sv
`timescale 1ns/1ps
module test_mem_req_reset_seq;

    localparam logic [4:0] IDLE_V = 5'b10100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] gen = 5'b00000;
    logic       ireq_n, iseq, dreq_n, dseq, dmore;
    logic [4:0] outv;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign outv = {ireq_n, iseq, dreq_n, dseq, dmore};

    mem_req_reset_seq i_mem_req_reset_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_ireq_n (gen[4]),
        .gen_iseq   (gen[3]),
        .gen_dreq_n (gen[2]),
        .gen_dseq   (gen[1]),
        .gen_dmore  (gen[0]),
        .ireq_n     (ireq_n),
        .iseq       (iseq),
        .dreq_n     (dreq_n),
        .dseq       (dseq),
        .dmore      (dmore)
    );

    function automatic logic [4:0] busy_req();
        logic [4:0] v;
        v    = 5'($urandom);
        v[4] = 1'b0;
        return v;
    endfunction

    function automatic logic [4:0] expect_out(input logic forced, input logic [4:0] g);
        return forced ? IDLE_V : g;
    endfunction

    task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic rise_mid();
        @(posedge clk);
        #1.25;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Release in a high phase, then the idle edges E, E+1 and the access at E+2.
    task automatic release_high(input string tag);
        rise_mid();
        rst_n = 1'b1;
        gen = busy_req();
        rise_mid();
        chk({tag, " R6 idle at E"}, outv, expect_out(1'b1, gen));
        gen = busy_req();
        #0.3 chk({tag, " R7 gen ignored in wait"}, outv, IDLE_V);
        rise_mid();
        chk({tag, " R6 idle at E+1"}, outv, IDLE_V);
        #2.5 chk({tag, " R6 idle late E+1"}, outv, IDLE_V);
        @(posedge clk);
        #1.25 chk({tag, " R6 first access at E+2"}, outv, gen);
    endtask

    task automatic pass_run(input int n);
        for (int i = 0; i < n; i++) begin
            #($urandom_range(1, 20) * 0.1);
            gen = 5'($urandom);
            #0.5 chk("R8 pass-through", outv, gen);
            @(posedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_2024));
        gen = busy_req();
        repeat (2) rise_mid();
        chk("R2 idle code", outv, 5'b10100);
        chk("R2 ireq_n field", {4'b0, ireq_n}, 5'b00001);
        for (int i = 0; i < 5; i++) begin
            gen = 5'($urandom);
            #0.3 chk("R1 R7 idle in reset", outv, IDLE_V);
            rise_mid();
        end

        release_high("first release");
        pass_run(60);

        // R3: drop in the high phase, idle at once.
        rise_mid();
        gen = busy_req();
        #0.2 chk("R8 before R3", outv, gen);
        rst_n = 1'b0;
        #0.3 chk("R3 immediate idle", outv, IDLE_V);
        repeat (2) begin
            rise_mid();
            chk("R1 held", outv, IDLE_V);
        end

        // R5: release just after a falling edge.
        @(negedge clk);
        #0.5 rst_n = 1'b1;
        gen = busy_req();
        @(posedge clk);
        #1.25 chk("R5 rising edge before sample", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R5 idle at E", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R5 idle at E+1", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R6 first access after R5 release", outv, gen);
        pass_run(30);

        // R4: drop in the low phase, deferred until the rising edge.
        @(negedge clk);
        #1.0 gen = busy_req();
        #0.1 rst_n = 1'b0;
        #0.5 chk("R4 still passing", outv, gen);
        #0.7 chk("R4 still passing late", outv, gen);
        @(posedge clk);
        #0.3 chk("R4 idle at rising edge", outv, IDLE_V);
        rise_mid();
        release_high("after R4");
        pass_run(30);

        // R9: pulse entirely inside one low phase.
        @(negedge clk);
        gen = busy_req();
        #0.8 rst_n = 1'b0;
        #0.6 rst_n = 1'b1;
        #0.3 chk("R9 deferred in low phase", outv, gen);
        @(posedge clk);
        #1.25 chk("R9 pulse caught", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R9 idle at E", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R9 idle at E+1", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R9 first access at E+2", outv, gen);
        pass_run(30);

        // R10: pulse entirely inside one high phase.
        @(posedge clk);
        gen = busy_req();
        #0.5 rst_n = 1'b0;
        #0.3 chk("R10 immediate idle", outv, IDLE_V);
        #0.4 rst_n = 1'b1;
        @(posedge clk);
        #1.25 chk("R10 idle at E", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R10 idle at E+1", outv, IDLE_V);
        @(posedge clk);
        #1.25 chk("R10 first access at E+2", outv, gen);
        pass_run(20);

        // Random reset lengths, each followed by the full release sequence.
        for (int k = 0; k < 15; k++) begin
            rise_mid();
            rst_n = 1'b0;
            #0.3 chk("R3 random drop", outv, IDLE_V);
            for (int j = 0; j < int'($urandom_range(1, 5)); j++) begin
                gen = 5'($urandom);
                rise_mid();
                chk("R1 R7 random hold", outv, IDLE_V);
            end
            release_high("random");
            pass_run(int'($urandom_range(3, 12)));
        end

        finish_run();
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule